// File: doc/BRIEF.md
# Effective Address Generator

This unit turns the operand bytes of an 8-bit processor instruction into a 16-bit effective address. It takes the addressing mode, the one or two operand bytes, both index registers and the address of the following instruction. Some modes first need a two-byte pointer from memory. For those modes the unit fetches the pointer through its own byte-wide read port, one byte after the other.

A request is presented with a one-cycle `start` while the unit is idle. Modes that need no memory finish in two cycles. Pointer modes take four cycles. The result appears with a one-cycle `done` pulse, together with a flag that marks an index or branch addition that moved into another 256-byte page. The result stays on the outputs until the next `done`. The caller may present the next request in the same cycle that `done` is high.

The read port has a fixed latency of one cycle. The byte requested while `rd_en` is high must be on `rd_data` in the following cycle.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is active, and after it is released, `busy`, `done`, `rd_en`, `page_cross` and `ea` are all zero.
- R2: `start` is accepted only when `busy` is low. A `start` seen while busy is ignored and does not change the running result. For an accepted request, `done` is a single-cycle pulse: two cycles after the accepting edge for modes without memory reads, and four cycles after it for pointer modes.
- R3: Mode code 0 (page zero) gives `ea` = {0x00, op_lo}. Mode code 3 (absolute) gives {op_hi, op_lo}. The unused codes 10 to 15 behave as code 3. In all these cases `page_cross` is 0.
- R4: Mode codes 1 (page zero + X) and 2 (page zero + Y) give a low byte equal to op_lo plus the index, modulo 256, with a high byte of 0x00 and `page_cross` at 0.
- R5: Mode codes 4 (absolute + X) and 5 (absolute + Y) add the index to {op_hi, op_lo} modulo 65536. `page_cross` equals the carry out of the low-byte addition.
- R6: Mode code 6 (branch) adds op_lo, read as a signed value from -128 to +127, to `base_pc`. `page_cross` is 1 when the high byte of the result differs from the high byte of `base_pc`.
- R7: Mode code 7 (X-indexed pointer) reads the byte at {0x00, op_lo+X} and then the byte at {0x00, op_lo+X+1}. Both low bytes are taken modulo 256, so the second read wraps from 0xFF to 0x00. `ea` is {second, first} and `page_cross` is 0.
- R8: Mode code 8 (pointer then + Y) reads the bytes at {0x00, op_lo} and {0x00, op_lo+1 mod 256}. It then adds Y to the pointer {second, first} modulo 65536. `page_cross` equals the carry out of the low-byte addition.
- R9: Mode code 9 (absolute pointer) reads the bytes at {op_hi, op_lo} and at that address plus one, with a carry into the high byte. `ea` is {second, first} and `page_cross` is 0.
- R10: `rd_en` is high for exactly two consecutive cycles per pointer request: first-byte address, then second-byte address. It is never high for the other modes. Each byte is taken from `rd_data` one cycle after its request.
- R11: `ea` and `page_cross` change only in a cycle where `done` is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| mode | input | 4 | Addressing mode code |
| op_lo | input | 8 | First operand byte (low address byte or branch offset) |
| op_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| base_pc | input | 16 | Address of the following instruction |
| rd_data | input | 8 | Byte returned one cycle after `rd_en` |
| rd_en | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Page boundary crossed by the addition |

## Verification
The bench issues back-to-back requests. As a result, the completion strobe of one request falls in the same cycle as the acceptance of the next request, in mixes of short and long modes. It also drives `start` in the busy cycle that follows acceptance, with different operands. A scoreboard judges both cases. It checks the arrival cycle and value of every result against the expected one. It also checks that every read address matches the expected pointer sequence, and it treats any extra `done` or read as a failure.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    M_ZP   = 4'd0,
    M_ZPX  = 4'd1,
    M_ZPY  = 4'd2,
    M_ABS  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_REL  = 4'd6,
    M_INDX = 4'd7,
    M_INDY = 4'd8,
    M_IND  = 4'd9
  } eag_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD0  = 2'd1,
    S_RD1  = 2'd2,
    S_CALC = 2'd3
  } eag_state_e;

  function automatic logic eag_needs_ptr(input logic [3:0] m);
    return (m == M_INDX) || (m == M_INDY) || (m == M_IND);
  endfunction

endpackage

// File: rtl/eag_ptr_gen.sv
module eag_ptr_gen
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic            second,
  output logic [2*DW-1:0] addr
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] zp_base;

  always_comb begin
    zp_base = (mode == M_INDX) ? (op_lo + idx_x) : op_lo;
    if ((mode == M_INDX) || (mode == M_INDY)) begin
      addr = {{DW{1'b0}}, zp_base + DW'(second)};
    end else begin
      addr = {op_hi, op_lo} + AW'(second);
    end
  end

endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [2*DW-1:0] base_pc,
  input  logic [DW-1:0]   ptr_lo,
  input  logic [DW-1:0]   ptr_hi,
  output logic [2*DW-1:0] ea,
  output logic            pcross
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] idx;
  logic [DW-1:0] blo;
  logic [DW-1:0] bhi;
  logic [DW:0]   lsum;
  logic [DW-1:0] hsum;
  logic [AW-1:0] rel;

  always_comb begin
    idx  = ((mode == M_ZPY) || (mode == M_ABSY) || (mode == M_INDY)) ? idx_y : idx_x;
    blo  = (mode == M_INDY) ? ptr_lo : op_lo;
    bhi  = (mode == M_INDY) ? ptr_hi : op_hi;
    lsum = {1'b0, blo} + {1'b0, idx};
    hsum = bhi + DW'(lsum[DW]);
    rel  = base_pc + {{DW{op_lo[DW-1]}}, op_lo};
    pcross = 1'b0;
    case (mode)
      M_ZP:                  ea = {{DW{1'b0}}, op_lo};
      M_ZPX, M_ZPY:          ea = {{DW{1'b0}}, lsum[DW-1:0]};
      M_ABSX, M_ABSY, M_INDY: begin
        ea     = {hsum, lsum[DW-1:0]};
        pcross = lsum[DW];
      end
      M_REL: begin
        ea     = rel;
        pcross = (rel[AW-1:DW] != base_pc[AW-1:DW]);
      end
      M_INDX, M_IND:         ea = {ptr_hi, ptr_lo};
      default:               ea = {op_hi, op_lo};
    endcase
  end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       mode,
  input  logic [DW-1:0]    op_lo,
  input  logic [DW-1:0]    op_hi,
  input  logic [DW-1:0]    idx_x,
  input  logic [DW-1:0]    idx_y,
  input  logic [2*DW-1:0]  base_pc,
  input  logic [DW-1:0]    rd_data,
  output logic             rd_en,
  output logic [2*DW-1:0]  rd_addr,
  output logic             busy,
  output logic             done,
  output logic [2*DW-1:0]  ea,
  output logic             page_cross
);
  localparam int AW = 2 * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  eag_state_e     state_q, state_d;
  logic [3:0]     mode_q;
  logic [DW-1:0]  lo_q, hi_q, x_q, y_q, ptrlo_q;
  logic [AW-1:0]  pc_q, ea_q, ea_w;
  logic           pcross_q, pcross_w, done_q;
  logic           accept, req_en, ptr_en, res_en;

  always_comb begin
    accept  = start && (state_q == S_IDLE);
    req_en  = accept;
    ptr_en  = (state_q == S_RD1);
    res_en  = (state_q == S_CALC);
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = eag_needs_ptr(mode) ? S_RD0 : S_CALC;
      S_RD0:  state_d = S_RD1;
      S_RD1:  state_d = S_CALC;
      S_CALC: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q  <= S_IDLE;
      mode_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      x_q      <= '0;
      y_q      <= '0;
      pc_q     <= '0;
      ptrlo_q  <= '0;
      ea_q     <= '0;
      pcross_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= res_en;
      if (req_en) begin
        mode_q <= mode;
        lo_q   <= op_lo;
        hi_q   <= op_hi;
        x_q    <= idx_x;
        y_q    <= idx_y;
        pc_q   <= base_pc;
      end
      if (ptr_en) ptrlo_q <= rd_data;
      if (res_en) begin
        ea_q     <= ea_w;
        pcross_q <= pcross_w;
      end
    end
  end

  eag_ptr_gen #(.DW(DW)) u_ptr (
    .mode   (mode_q),
    .op_lo  (lo_q),
    .op_hi  (hi_q),
    .idx_x  (x_q),
    .second (state_q == S_RD1),
    .addr   (rd_addr)
  );

  eag_calc #(.DW(DW)) u_calc (
    .mode    (mode_q),
    .op_lo   (lo_q),
    .op_hi   (hi_q),
    .idx_x   (x_q),
    .idx_y   (y_q),
    .base_pc (pc_q),
    .ptr_lo  (ptrlo_q),
    .ptr_hi  (rd_data),
    .ea      (ea_w),
    .pcross  (pcross_w)
  );

  assign rd_en      = (state_q == S_RD0) || (state_q == S_RD1);
  assign busy       = (state_q != S_IDLE);
  assign done       = done_q;
  assign ea         = ea_q;
  assign page_cross = pcross_q;

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_s)
    start && !busy |=> busy);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R4
  zp_high_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done && ((mode_q == M_ZP) || (mode_q == M_ZPX) || (mode_q == M_ZPY))
      |-> (ea[AW-1:DW] == '0));
  // R7
  ptr_page0_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en && ((mode_q == M_INDX) || (mode_q == M_INDY)) |-> (rd_addr[AW-1:DW] == '0));
  // R10
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en && !$past(rd_en) |=> rd_en);
  // R10
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en && $past(rd_en) |=> !rd_en);
  // R5
  pcross_mode_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done && page_cross |-> ((mode_q == M_ABSX) || (mode_q == M_ABSY) ||
                            (mode_q == M_REL) || (mode_q == M_INDY)));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(ea) |-> done);

endmodule

// File: tb/eff_addr_gen_bench.sv
`timescale 1ns/1ps
module eff_addr_gen_bench;
  localparam int DW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start, rd_en, busy, done, page_cross;
  logic [3:0]    mode;
  logic [DW-1:0] op_lo, op_hi, idx_x, idx_y, rd_data;
  logic [AW-1:0] base_pc, rd_addr, ea;

  eff_addr_gen #(.DW(DW)) u_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .base_pc(base_pc),
    .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
    .done(done), .ea(ea), .page_cross(page_cross)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  bit have_last = 1'b0;
  logic [AW-1:0] last_ea;
  logic          last_pc;

  logic [AW-1:0] q_ea[$];
  logic          q_pc[$];
  int            q_t[$];
  string         q_tag[$];
  logic [AW-1:0] q_rd[$];
  string         q_rtag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ 8'(a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  always @(posedge clk) rd_data <= rd_en ? memf(rd_addr) : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (done) begin
        if (q_ea.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 32'(ea), 32'hFFFFFFFF);
        end else begin
          automatic logic [AW-1:0] e = q_ea.pop_front();
          automatic logic p = q_pc.pop_front();
          automatic int t = q_t.pop_front();
          automatic string tg = q_tag.pop_front();
          chk(ea == e, tg, "ea", 32'(ea), 32'(e));
          chk(page_cross == p, tg, "page_cross", 32'(page_cross), 32'(p));
          chk(cyc == t, "R2", "done cycle", 32'(cyc), 32'(t));
        end
        have_last = 1'b1;
        last_ea = ea;
        last_pc = page_cross;
      end else if (have_last) begin
        // R11 outputs hold between strobes
        chk(ea == last_ea && page_cross == last_pc, "R11", "hold",
            32'({ea, page_cross}), 32'({last_ea, last_pc}));
      end
      if (rd_en) begin
        if (q_rd.size() == 0) begin
          chk(1'b0, "R10", "unexpected read", 32'(rd_addr), 32'hFFFFFFFF);
        end else begin
          automatic logic [AW-1:0] a = q_rd.pop_front();
          automatic string rt = q_rtag.pop_front();
          chk(rd_addr == a, rt, "read address", 32'(rd_addr), 32'(a));
        end
      end
    end
  end

  task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                       input string tag, input bit poke);
    logic [15:0] e, a0, a1, ptr;
    logic p;
    bit rd;
    p = 1'b0; rd = 1'b0; a0 = '0; a1 = '0;
    case (m)
      4'd0: e = {8'h00, lo};
      4'd1: e = {8'h00, 8'(lo + x)};
      4'd2: e = {8'h00, 8'(lo + y)};
      4'd4: begin e = {hi, lo} + 16'(x); p = (9'(lo) + 9'(x)) > 9'd255; end
      4'd5: begin e = {hi, lo} + 16'(y); p = (9'(lo) + 9'(y)) > 9'd255; end
      4'd6: begin e = pc + {{8{lo[7]}}, lo}; p = (e[15:8] != pc[15:8]); end
      4'd7: begin
        rd = 1'b1; a0 = {8'h00, 8'(lo + x)}; a1 = {8'h00, 8'(lo + x + 8'd1)};
        e = {memf(a1), memf(a0)};
      end
      4'd8: begin
        rd = 1'b1; a0 = {8'h00, lo}; a1 = {8'h00, 8'(lo + 8'd1)};
        ptr = {memf(a1), memf(a0)};
        e = ptr + 16'(y); p = (9'(memf(a0)) + 9'(y)) > 9'd255;
      end
      4'd9: begin
        rd = 1'b1; a0 = {hi, lo}; a1 = {hi, lo} + 16'd1;
        e = {memf(a1), memf(a0)};
      end
      default: e = {hi, lo};
    endcase
    while (busy) @(negedge clk);
    mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; base_pc = pc;
    start = 1'b1;
    q_ea.push_back(e); q_pc.push_back(p); q_tag.push_back(tag);
    q_t.push_back(cyc + (rd ? 4 : 2));
    if (rd) begin
      q_rd.push_back(a0); q_rtag.push_back(tag);
      q_rd.push_back(a1); q_rtag.push_back(tag);
    end
    @(negedge clk);
    if (poke) begin
      // R2 start while busy must be ignored
      mode = 4'd3; op_lo = 8'hAA; op_hi = 8'h55; idx_x = 8'h11; base_pc = 16'h7777;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; op_lo = '0; op_hi = '0;
    idx_x = '0; idx_y = '0; base_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, rd_en, page_cross} == 4'b0, "R1", "flags in reset",
        32'({busy, done, rd_en, page_cross}), 32'h0);
    chk(ea == 16'h0, "R1", "ea in reset", 32'(ea), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, rd_en, page_cross} == 4'b0 && ea == 16'h0, "R1", "after release",
        32'({busy, done, rd_en, page_cross, ea}), 32'h0);
    running = 1'b1;

    issue(4'd0, 8'h8F, 8'h12, 8'h00, 8'h00, 16'h0, "R3", 1'b0);
    issue(4'd3, 8'h12, 8'h34, 8'h05, 8'h00, 16'h0, "R3", 1'b1);
    issue(4'd12, 8'hCD, 8'hAB, 8'h05, 8'h00, 16'h0, "R3", 1'b0);
    issue(4'd1, 8'hF0, 8'h99, 8'h20, 8'h00, 16'h0, "R4", 1'b0);
    issue(4'd2, 8'h05, 8'h99, 8'h77, 8'h03, 16'h0, "R4", 1'b0);
    issue(4'd4, 8'hFF, 8'h12, 8'h01, 8'h00, 16'h0, "R5", 1'b0);
    issue(4'd5, 8'h10, 8'h20, 8'h00, 8'h05, 16'h0, "R5", 1'b1);
    issue(4'd4, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0, "R5", 1'b0);
    issue(4'd6, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h1280, "R6", 1'b0);
    issue(4'd6, 8'h20, 8'h00, 8'h00, 8'h00, 16'h12F0, "R6", 1'b0);
    issue(4'd6, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1205, "R6", 1'b0);
    issue(4'd6, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0000, "R6", 1'b0);
    issue(4'd7, 8'h80, 8'h44, 8'h10, 8'h00, 16'h0, "R7", 1'b1);
    issue(4'd7, 8'hFE, 8'h44, 8'h01, 8'h00, 16'h0, "R7", 1'b0);
    issue(4'd0, 8'h01, 8'h00, 8'h00, 8'h00, 16'h0, "R3", 1'b0);
    issue(4'd8, 8'h40, 8'h00, 8'h00, 8'h10, 16'h0, "R8", 1'b0);
    issue(4'd8, 8'hFF, 8'h00, 8'h00, 8'hF0, 16'h0, "R8", 1'b1);
    issue(4'd9, 8'h20, 8'h30, 8'h00, 8'h00, 16'h0, "R9", 1'b0);
    issue(4'd9, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0, "R9", 1'b0);
    issue(4'd5, 8'hF8, 8'h00, 8'h00, 8'h08, 16'h0, "R5", 1'b0);

    while (busy || q_ea.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    // R2 / R10 nothing left over, no stray strobes or reads
    chk(q_ea.size() == 0, "R2", "pending results", 32'(q_ea.size()), 32'h0);
    chk(q_rd.size() == 0, "R10", "pending reads", 32'(q_rd.size()), 32'h0);
    chk(!rd_en && !busy, "R10", "idle after run", 32'({rd_en, busy}), 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule